// File: doc/BRIEF.md
# Dual-Format Audio Serial Transmitter

This block turns a stereo pair of 32-bit audio words into a single serial data line, framed by a bit clock and a frame-sync signal. Two framings are supported: I2S, where the left channel occupies the low phase of frame sync and each word starts one bit clock late, and left-justified, where the left channel occupies the high phase and each word starts at once. Every word goes out most significant bit first, and any bit clocks in a phase after the word has been sent carry zeros.

The block runs on a fast system clock and samples the bit clock as an ordinary input. It detects the bit-clock edges itself, so all of its state changes on single-cycle strobes. As a slave it follows an external frame sync. As a master it toggles its own frame sync after a programmable number of bit clocks per half frame, clamped to a legal range. A new left/right pair is offered through a valid/ready handshake into a one-entry holding register and is taken into the shifter at the start of each frame. If no pair is waiting at that point, the last pair is sent again and an under-run strobe is raised. In slave mode, a frame-sync edge that cuts a slot short sets a sticky error flag, abandons the unfinished slot and starts the new slot cleanly.

Top module: `aud_ser_tx`

## Requirements
- R1: Each slot carries one 32-bit word, most significant bit first, one bit per bit-clock cycle.
- R2: Bit-clock cycles of a frame-sync phase that carry no word bit drive 0 on `sdata_o`.
- R3: In left-justified format (`cfg_i2s_i`=0) the left word is sent while frame sync is 1 and the right word while it is 0, and the MSB goes out in the first bit-clock cycle of the phase.
- R4: In I2S format (`cfg_i2s_i`=1) the left word is sent while frame sync is 0 and the right word while it is 1, and the MSB goes out in the second bit-clock cycle of the phase. The first cycle carries the previous word's LSB when the previous phase was exactly 32 bit clocks long, and 0 otherwise.
- R5: `sdata_o` changes only in the system-clock cycle after a falling bit-clock edge has been observed.
- R6: In master mode (`cfg_master_i`=1), `fsync_o` toggles after every N rising bit-clock edges, where N is `cfg_half_i` clamped to the range 32..256, and it changes only after a rising bit-clock edge. `fsync_o` starts at 0 after reset.
- R7: `s_ready_o` is 1 when the holding register is empty. A handshake fills it, and the start of the next frame empties it by moving the pair into the shifter.
- R8: At a frame start with the holding register empty, the previous pair is sent again, and `underrun_o` is 1 for exactly one system-clock cycle.
- R9: In slave mode, a frame-sync transition before the current slot is finished sets `frame_err_o`, which stays set until reset. In left-justified format, "before finished" means fewer than 32 bits sent. In I2S format, it means more than one bit still pending. The unfinished slot is dropped, and the new slot starts from its MSB.
- R10: After reset, `sdata_o`, `fsync_o`, `underrun_o` and `frame_err_o` are 0 and `s_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_i2s_i | input | 1 | Format select: 1 = I2S, 0 = left-justified |
| cfg_master_i | input | 1 | 1 = generate frame sync, 0 = follow `fsync_i` |
| cfg_half_i | input | 9 | Bit clocks per frame-sync phase in master mode |
| s_valid_i | input | 1 | A new sample pair is offered |
| s_ready_o | output | 1 | Holding register can accept a pair |
| s_left_i | input | 32 | Left channel word |
| s_right_i | input | 32 | Right channel word |
| bclk_i | input | 1 | Bit clock, sampled on `clk` |
| fsync_i | input | 1 | External frame sync (slave mode) |
| fsync_o | output | 1 | Generated frame sync (master mode) |
| sdata_o | output | 1 | Serial audio data |
| underrun_o | output | 1 | One-cycle strobe: frame started without a new pair |
| frame_err_o | output | 1 | Sticky slave-mode framing error |

## Verification
On every cycle, the assertions check the following:
- the data line moves only after a falling bit-clock edge, and the generated frame sync only after a rising one;
- the half-frame counter stays below the clamped length;
- the slot bit counter never exceeds 32;
- the under-run strobe lasts one cycle and leaves the shifter's pair untouched;
- a handshake always fills the holding register;
- the error flag never clears.

Only the bench's scenarios can show that the bits on the wire are the right ones. That covers MSB-first order, the one-bit I2S delay and the LSB that spills into the next phase, zero padding in long phases, clamping of the half-frame length, repetition of the old pair after an under-run, and a clean restart of a new slot after a short one.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

    localparam int SLOT_W = 32;
    localparam int CNT_W  = $clog2(SLOT_W + 1);

    typedef enum logic { FMT_LJ = 1'b0, FMT_I2S = 1'b1 } fmt_e;
    typedef enum logic { ROLE_SLAVE = 1'b0, ROLE_MASTER = 1'b1 } role_e;

    typedef logic [SLOT_W-1:0] word_t;

    typedef struct packed {
        word_t left;
        word_t right;
    } pair_t;

    // Slot request latched at a rising bit-clock edge, consumed at the next falling edge.
    typedef struct packed {
        logic start;
        logic left;
    } slot_req_t;

    // Frame-sync level that marks the left slot for a given format.
    function automatic logic left_level(fmt_e f);
        return (f == FMT_LJ);
    endfunction

    function automatic word_t pick_word(pair_t p, logic is_left);
        return is_left ? p.left : p.right;
    endfunction

endpackage

// File: rtl/aud_tx_frame_ctrl.sv
module aud_tx_frame_ctrl
    import aud_tx_pkg::*;
#(
    parameter int HALF_W   = 9,
    parameter int MIN_HALF = 32,
    parameter int MAX_HALF = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  fmt_e              fmt,
    input  role_e             role,
    input  logic [HALF_W-1:0] half_len,
    input  logic              bclk_i,
    input  logic              fsync_i,
    output logic              bclk_fall,
    output slot_req_t         req,
    output logic              frame_start,
    output logic              fsync_o
);

    localparam logic [HALF_W-1:0] LO_LEN = HALF_W'(MIN_HALF);
    localparam logic [HALF_W-1:0] HI_LEN = HALF_W'(MAX_HALF);

    logic              bclk_q;
    logic              bclk_rise;
    logic [HALF_W-1:0] eff_len;
    logic [HALF_W-1:0] half_cnt;
    logic              fs_int;
    logic              fs_next;
    logic              fs_now;
    logic              fs_prev;
    logic              fs_edge;
    logic              wrap;

    assign bclk_rise = bclk_i & ~bclk_q;
    assign bclk_fall = ~bclk_i & bclk_q;

    always_comb begin
        if (half_len < LO_LEN)      eff_len = LO_LEN;
        else if (half_len > HI_LEN) eff_len = HI_LEN;
        else                        eff_len = half_len;
    end

    assign wrap        = (half_cnt >= eff_len - 1'b1);
    assign fs_next     = wrap ? ~fs_int : fs_int;
    assign fs_now      = (role == ROLE_MASTER) ? fs_next : fsync_i;
    assign fs_edge     = bclk_rise && (fs_now != fs_prev);
    assign frame_start = fs_edge && (fs_now == left_level(fmt));
    assign fsync_o     = fs_int;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q   <= 1'b0;
            half_cnt <= '0;
            fs_int   <= 1'b0;
            fs_prev  <= 1'b0;
            req      <= '0;
        end else begin
            bclk_q <= bclk_i;
            if (bclk_rise) begin
                fs_prev   <= fs_now;
                req.start <= fs_edge;
                req.left  <= (fs_now == left_level(fmt));
                if (role == ROLE_MASTER) begin
                    half_cnt <= wrap ? '0 : half_cnt + 1'b1;
                    fs_int   <= fs_next;
                end
            end else if (bclk_fall) begin
                req.start <= 1'b0;
            end
        end
    end

    assert_fsync_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(fsync_o) |-> ($past(bclk_i) && $past(role == ROLE_MASTER)))
        else $error("fsync_o moved without a rising bit clock in master mode");

    assert_half_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
        (role == ROLE_MASTER) |-> (half_cnt < eff_len))
        else $error("half-frame counter beyond clamped length");

endmodule

// File: rtl/aud_tx_sample_buf.sv
module aud_tx_sample_buf
    import aud_tx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  s_valid,
    output logic  s_ready,
    input  pair_t s_pair,
    input  logic  frame_start,
    output pair_t active,
    output logic  underrun
);

    pair_t hold;
    logic  full;

    assign s_ready = ~full;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold     <= '0;
            full     <= 1'b0;
            active   <= '0;
            underrun <= 1'b0;
        end else begin
            underrun <= 1'b0;
            if (frame_start) begin
                if (full) begin
                    active <= hold;
                    full   <= 1'b0;
                end else begin
                    underrun <= 1'b1;
                end
            end
            if (s_valid && !full) begin
                hold <= s_pair;
                full <= 1'b1;
            end
        end
    end

    assert_handshake_fills_R7: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_ready) |=> !s_ready)
        else $error("accepted pair did not fill holding register");

    assert_underrun_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        underrun |=> !underrun)
        else $error("under-run strobe longer than one cycle");

    assert_repeat_on_underrun_R8: assert property (@(posedge clk) disable iff (rst)
        underrun |-> $stable(active))
        else $error("shifter pair changed on an under-run");

endmodule

// File: rtl/aud_tx_slot_shifter.sv
module aud_tx_slot_shifter
    import aud_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  fmt_e      fmt,
    input  role_e     role,
    input  logic      bclk_fall,
    input  slot_req_t req,
    input  pair_t     active,
    output logic      sdata,
    output logic      frame_err
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(SLOT_W);
    localparam logic [CNT_W-1:0] LJ_CNT   = CNT_W'(SLOT_W - 1);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

    word_t            shreg;
    logic [CNT_W-1:0] remain;
    word_t            next_word;
    logic             cut_short;

    assign next_word = pick_word(active, req.left);

    always_comb begin
        if (fmt == FMT_LJ) cut_short = (remain != '0);
        else               cut_short = (remain > ONE_CNT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            remain    <= '0;
            sdata     <= 1'b0;
            frame_err <= 1'b0;
        end else if (bclk_fall) begin
            if (req.start) begin
                if (cut_short && role == ROLE_SLAVE) frame_err <= 1'b1;
                if (fmt == FMT_LJ) begin
                    sdata  <= next_word[SLOT_W-1];
                    shreg  <= {next_word[SLOT_W-2:0], 1'b0};
                    remain <= LJ_CNT;
                end else begin
                    sdata  <= (remain == ONE_CNT) ? shreg[SLOT_W-1] : 1'b0;
                    shreg  <= next_word;
                    remain <= FULL_CNT;
                end
            end else if (remain != '0) begin
                sdata  <= shreg[SLOT_W-1];
                shreg  <= {shreg[SLOT_W-2:0], 1'b0};
                remain <= remain - 1'b1;
            end else begin
                sdata <= 1'b0;
            end
        end
    end

    assert_slot_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
        remain <= FULL_CNT)
        else $error("slot bit counter above word length");

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> frame_err)
        else $error("framing error flag cleared without reset");

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
    import aud_tx_pkg::*;
#(
    parameter int HALF_W   = 9,
    parameter int MIN_HALF = 32,
    parameter int MAX_HALF = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_i2s_i,
    input  logic              cfg_master_i,
    input  logic [HALF_W-1:0] cfg_half_i,
    input  logic              s_valid_i,
    output logic              s_ready_o,
    input  logic [SLOT_W-1:0] s_left_i,
    input  logic [SLOT_W-1:0] s_right_i,
    input  logic              bclk_i,
    input  logic              fsync_i,
    output logic              fsync_o,
    output logic              sdata_o,
    output logic              underrun_o,
    output logic              frame_err_o
);

    fmt_e      fmt;
    role_e     role;
    logic      bclk_fall;
    logic      frame_start;
    slot_req_t req;
    pair_t     in_pair;
    pair_t     active;

    assign fmt           = fmt_e'(cfg_i2s_i);
    assign role          = role_e'(cfg_master_i);
    assign in_pair.left  = s_left_i;
    assign in_pair.right = s_right_i;

    aud_tx_frame_ctrl #(
        .HALF_W   (HALF_W),
        .MIN_HALF (MIN_HALF),
        .MAX_HALF (MAX_HALF)
    ) frame_i (
        .clk         (clk),
        .rst         (rst),
        .fmt         (fmt),
        .role        (role),
        .half_len    (cfg_half_i),
        .bclk_i      (bclk_i),
        .fsync_i     (fsync_i),
        .bclk_fall   (bclk_fall),
        .req         (req),
        .frame_start (frame_start),
        .fsync_o     (fsync_o)
    );

    aud_tx_sample_buf buf_i (
        .clk         (clk),
        .rst         (rst),
        .s_valid     (s_valid_i),
        .s_ready     (s_ready_o),
        .s_pair      (in_pair),
        .frame_start (frame_start),
        .active      (active),
        .underrun    (underrun_o)
    );

    aud_tx_slot_shifter shift_i (
        .clk       (clk),
        .rst       (rst),
        .fmt       (fmt),
        .role      (role),
        .bclk_fall (bclk_fall),
        .req       (req),
        .active    (active),
        .sdata     (sdata_o),
        .frame_err (frame_err_o)
    );

    assert_data_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdata_o) |-> (!$past(bclk_i) && $past(bclk_i, 2)))
        else $error("sdata_o moved without a falling bit clock");

endmodule

// File: tb/aud_ser_tx_tb_top.sv
module aud_ser_tx_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_i2s, cfg_master;
    logic [8:0]  cfg_half;
    logic        s_valid, s_ready;
    logic [31:0] s_left, s_right;
    logic        bclk, fsync_in, fsync_out, sdata, underrun, frame_err;

    int checks = 0;
    int errors = 0;
    int urun_cnt;
    int rec_n;
    logic rec_bit [0:2047];
    logic rec_fs  [0:2047];

    always #5 clk = ~clk;

    aud_ser_tx dut_i (
        .clk(clk), .rst(rst), .cfg_i2s_i(cfg_i2s), .cfg_master_i(cfg_master),
        .cfg_half_i(cfg_half), .s_valid_i(s_valid), .s_ready_o(s_ready),
        .s_left_i(s_left), .s_right_i(s_right), .bclk_i(bclk), .fsync_i(fsync_in),
        .fsync_o(fsync_out), .sdata_o(sdata), .underrun_o(underrun), .frame_err_o(frame_err)
    );

    always @(posedge clk) begin
        if (rst) urun_cnt <= 0;
        else if (underrun) urun_cnt <= urun_cnt + 1;
    end

    typedef struct packed {
        logic        i2s;
        logic        master;
        logic [8:0]  half;
        logic [9:0]  eff;
        logic [31:0] left;
        logic [31:0] right;
    } vec_t;

    localparam vec_t VECS [0:6] = '{
        '{1'b0, 1'b0, 9'd32,  10'd32,  32'h8000_0001, 32'hA5A5_3C3C},
        '{1'b0, 1'b0, 9'd40,  10'd40,  32'h1234_5678, 32'hFEDC_BA98},
        '{1'b1, 1'b0, 9'd32,  10'd32,  32'hC000_0003, 32'h0F0F_F0F1},
        '{1'b1, 1'b0, 9'd48,  10'd48,  32'hDEAD_BEEF, 32'h7654_3211},
        '{1'b0, 1'b1, 9'd20,  10'd32,  32'h8765_4321, 32'h0000_0001},
        '{1'b1, 1'b1, 9'd64,  10'd64,  32'hCAFE_F00D, 32'h8000_0000},
        '{1'b0, 1'b1, 9'd300, 10'd256, 32'h55AA_33CC, 32'hB00B_1E55}
    };

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected bit at position p of a phase, derived from R1..R4.
    function automatic logic exp_bit(logic i2s, int p, logic [31:0] w, int prev_len, logic [31:0] prev_w);
        if (!i2s) return (p < 32) ? w[31-p] : 1'b0;
        if (p == 0) return (prev_len == 32) ? prev_w[0] : 1'b0;
        return (p <= 32) ? w[32-p] : 1'b0;
    endfunction

    task automatic check_phase(int base, int len, logic [31:0] w, int prev_len,
                               logic [31:0] prev_w, logic i2s, string fmt_tag);
        for (int p = 0; p < len; p++) begin
            string tag;
            logic  data_pos;
            data_pos = i2s ? (p >= 1 && p <= 32) : (p < 32);
            if (data_pos)            tag = {"R1/", fmt_tag};
            else if (i2s && p == 0)  tag = "R4";
            else                     tag = "R2";
            check(tag, $sformatf("bit pos %0d", p), {31'd0, rec_bit[base+p]},
                  {31'd0, exp_bit(i2s, p, w, prev_len, prev_w)});
        end
    endtask

    task automatic cyc(input logic fs);
        @(negedge clk); bclk = 1'b1; fsync_in = fs;
        @(negedge clk);
        @(negedge clk); bclk = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rec_bit[rec_n] = sdata;
        rec_fs[rec_n]  = fsync_out;
        rec_n++;
    endtask

    task automatic do_reset(logic i2s, logic master, logic [8:0] half);
        rst = 1'b1; bclk = 1'b0; fsync_in = 1'b0; s_valid = 1'b0;
        s_left = '0; s_right = '0;
        cfg_i2s = i2s; cfg_master = master; cfg_half = half;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rec_n = 0;
        // R10 reset state
        check("R10", "sdata_o",     {31'd0, sdata},     32'd0);
        check("R10", "fsync_o",     {31'd0, fsync_out}, 32'd0);
        check("R10", "underrun_o",  {31'd0, underrun},  32'd0);
        check("R10", "frame_err_o", {31'd0, frame_err}, 32'd0);
        check("R10", "s_ready_o",   {31'd0, s_ready},   32'd1);
    endtask

    task automatic push(logic [31:0] l, logic [31:0] r);
        check("R7", "ready before push", {31'd0, s_ready}, 32'd1);
        @(negedge clk); s_valid = 1'b1; s_left = l; s_right = r;
        @(negedge clk); s_valid = 1'b0;
        check("R7", "ready after push", {31'd0, s_ready}, 32'd0);
    endtask

    task automatic run_slave(vec_t v);
        logic idle_lvl, left_lvl;
        int   len, b0;
        logic trail_exp;
        len      = int'(v.half);
        left_lvl = ~v.i2s;
        idle_lvl = v.i2s;
        repeat (40) cyc(idle_lvl);
        push(v.left, v.right);
        b0 = rec_n;
        repeat (len) cyc(left_lvl);
        repeat (len) cyc(~left_lvl);
        cyc(left_lvl);
        check_phase(b0, len, v.left, 40, 32'd0, v.i2s, v.i2s ? "R4" : "R3");
        check_phase(b0 + len, len, v.right, len, v.left, v.i2s, v.i2s ? "R4" : "R3");
        // Trailing frame start: I2S spill (R4) or repeated left MSB after under-run (R8)
        trail_exp = v.i2s ? ((len == 32) ? v.right[0] : 1'b0) : v.left[31];
        check(v.i2s ? "R4" : "R8", "trailing bit", {31'd0, rec_bit[b0 + 2*len]}, {31'd0, trail_exp});
        check("R8", "under-run strobes", urun_cnt, 32'd1);
        check("R7", "ready after frame start", {31'd0, s_ready}, 32'd1);
        check("R9", "no framing error", {31'd0, frame_err}, 32'd0);
    endtask

    task automatic run_master(vec_t v);
        int   eff, t0, last, expect_t0;
        logic prev, left_lvl, trail_exp;
        eff      = int'(v.eff);
        left_lvl = ~v.i2s;
        push(v.left, v.right);
        repeat (4*eff + 2) cyc(1'b0);
        prev = 1'b0; t0 = -1; last = -1;
        for (int i = 0; i < rec_n; i++) begin
            if (rec_fs[i] != prev) begin
                if (last >= 0) check("R6", "half-frame length", i - last, eff);
                last = i;
                if (t0 < 0 && rec_fs[i] == left_lvl) t0 = i;
            end
            prev = rec_fs[i];
        end
        expect_t0 = v.i2s ? (2*eff - 1) : (eff - 1);
        check("R6", "first left phase", t0, expect_t0);
        if (t0 >= 0) begin
            check_phase(t0, eff, v.left, eff, 32'd0, v.i2s, v.i2s ? "R4" : "R3");
            check_phase(t0 + eff, eff, v.right, eff, v.left, v.i2s, v.i2s ? "R4" : "R3");
            trail_exp = v.i2s ? ((eff == 32) ? v.right[0] : 1'b0) : v.left[31];
            check("R8", "trailing bit", {31'd0, rec_bit[t0 + 2*eff]}, {31'd0, trail_exp});
        end
        check("R8", "under-run strobes", urun_cnt, 32'd1);
        check("R9", "no error in master", {31'd0, frame_err}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        for (int i = 0; i < 7; i++) begin
            do_reset(VECS[i].i2s, VECS[i].master, VECS[i].half);
            if (VECS[i].master) run_master(VECS[i]);
            else                run_slave(VECS[i]);
        end

        // R9: short left slot in slave left-justified mode
        do_reset(1'b0, 1'b0, 9'd32);
        repeat (5) cyc(1'b0);
        push(32'h1357_9BDF, 32'hF00D_CAFE);
        repeat (20) cyc(1'b1);
        check("R9", "flag before short edge", {31'd0, frame_err}, 32'd0);
        begin
            int b;
            b = rec_n;
            repeat (40) cyc(1'b0);
            check("R9", "flag after short slot", {31'd0, frame_err}, 32'd1);
            check_phase(b, 40, 32'hF00D_CAFE, 20, 32'd0, 1'b0, "R9");
        end
        repeat (40) cyc(1'b1);
        check("R9", "flag stays set", {31'd0, frame_err}, 32'd1);

        // R9: short slot in I2S slave mode (more than one bit pending)
        do_reset(1'b1, 1'b0, 9'd32);
        repeat (40) cyc(1'b1);
        push(32'hAAAA_5555, 32'h0123_4567);
        repeat (10) cyc(1'b0);
        repeat (40) cyc(1'b1);
        check("R9", "I2S short slot flag", {31'd0, frame_err}, 32'd1);

        // R2: a short phase never leaves stale bits: the padding of the long phase after it stays 0
        check("R2", "padding after restart", {31'd0, rec_bit[rec_n - 1]}, 32'd0);

        report();
        $finish;
    end

endmodule